// File: doc/BRIEF.md
# Configurable Quad-Lane Flash Read Sequencer

This block runs one read transaction against a serial flash over a four-lane data bus. Software first sets a 32-bit configuration word. It holds the read opcode, a lane width for each of the instruction, address and data phases, an optional mode-byte phase and a dummy-clock count. A one-cycle start pulse then supplies the 24-bit target address and the mode byte. The block lowers chip select and runs the serial clock at half the system clock. It shifts out the opcode, the address and the mode byte, waits out the dummy clocks and collects a fixed number of data bytes. Each byte appears on a byte output with a one-cycle valid strobe.

The configuration and the start arguments are captured when a transaction is accepted. Configuration writes made during a transfer therefore affect only later transfers. Outputs change while the serial clock is low, and inputs are sampled on the edge that raises it.

Top module: `qspi_read_seq`

## Requirements
- R1: After reset the configuration word reads 0x00000003: opcode 0x03, all lane widths single, mode phase off, zero dummy clocks.
- R2: Writable fields are opcode [7:0], instruction width [9:8], address width [13:12], data width [17:16], mode enable [20] and dummy count [28:24]. Every other bit reads 0 whatever is written, so writing all ones reads back 0x1F1333FF. The word holds its value when no write occurs.
- R3: With no transfer, chip select is high, the serial clock is low and busy is low. A transfer lowers chip select one system clock before the first rising serial clock edge. Chip select rises one clock after the last rising edge, so it stays low for exactly 2×(total serial beats) clocks. Busy equals the inverse of chip select throughout.
- R4: The opcode is sent most significant bit first. A lane-width code of 0 means 1 lane (DQ0), 1 means 2 lanes (DQ0–DQ1) and 2 means 4 lanes (DQ0–DQ3). Within one beat the higher-numbered lane carries the more significant bit, and only the lanes in use are driven.
- R5: The 24 address bits follow the opcode, MSB first, at the address width.
- R6: When the instruction width is 1 or 2, the address, mode and data phases use that width regardless of their own fields.
- R7: When mode enable is set, the 8-bit mode byte follows the address at the address width. When it is clear, no mode beats occur.
- R8: The dummy count N (0 to 31) inserts exactly N serial clocks between the last address or mode beat and the first data beat.
- R9: NUM_BYTES bytes are received MSB first at the data width, with DQ1 as the input in single mode. Each byte is presented with rd_valid high for one clock.
- R10: During dummy and data beats, no lane is driven in dual or quad data mode. In single data mode only DQ0 is driven, and it is driven low.
- R11: A lane-width code of 3 in any width field behaves as code 0.
- R12: A start pulse while busy is ignored, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read value |
| start | input | 1 | Start a read transfer (honoured only when idle) |
| start_addr | input | ADDR_W | Target address |
| mode_byte | input | 8 | Mode byte sent when enabled |
| busy | output | 1 | Transfer in progress |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| dq_out | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_in | input | 4 | Lane input values |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data valid strobe |

## Verification
The bench goes after lane order inside a beat and phase boundaries when widths differ between phases. A design that swapped lanes or lost continuity at a width change would send a corrupted address or mode byte. It also covers the dummy-count extremes of 0, 1 and 31, where an off-by-one would shift every data bit. In single data mode the bench drives DQ0 with the inverse of DQ1, so sampling the wrong lane returns complemented bytes. Width code 3, forced dual/quad instructions and a start pulse during a busy transfer are also exercised; a design that mishandled these would drive the wrong lanes or restart mid-frame.

// File: rtl/qspi_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the quad-lane flash read sequencer.
// Assumes lane widths are carried as log2 of the lane count (0,1,2).
package qspi_seq_pkg;

    typedef logic [1:0] lw_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_INST, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA
    } phase_e;

    typedef struct packed {
        logic [4:0] dummy;
        logic       mode_en;
        lw_t        w_data;
        lw_t        w_addr;
        lw_t        w_inst;
        logic [7:0] opcode;
    } rd_cfg_t;

    localparam logic [31:0] CFG_WMASK = 32'h1F13_33FF;
    localparam logic [31:0] CFG_RESET = 32'h0000_0003;

    // Map a raw width code to a lane exponent; code 3 falls back to one lane.
    function automatic lw_t norm_width(input logic [1:0] code);
        return (code == 2'd3) ? 2'd0 : code;
    endfunction

    // Output-enable pattern for the lanes that carry a given width.
    function automatic logic [3:0] lane_mask(input lw_t w);
        case (w)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/qspi_cfg_reg.sv
`timescale 1ns/1ps
// Read-command configuration word. Keeps only writable bits, so reserved
// bits read as zero. Also decodes the word into effective phase settings.
// Assumes a single-cycle write strobe.
module qspi_cfg_reg
    import qspi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output rd_cfg_t     cfg
);

    logic [31:0] cfg_q;
    lw_t         wi;

    // Store the writable subset of each write.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= CFG_RESET;
        else if (we) cfg_q <= wdata & CFG_WMASK;
    end

    assign rdata = cfg_q;

    // Decode fields; a multi-lane instruction width overrides the others.
    always_comb begin
        wi          = norm_width(cfg_q[9:8]);
        cfg.opcode  = cfg_q[7:0];
        cfg.w_inst  = wi;
        cfg.w_addr  = (wi != 2'd0) ? wi : norm_width(cfg_q[13:12]);
        cfg.w_data  = (wi != 2'd0) ? wi : norm_width(cfg_q[17:16]);
        cfg.mode_en = cfg_q[20];
        cfg.dummy   = cfg_q[28:24];
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata)); // R2

endmodule

// File: rtl/qspi_phase_seq.sv
`timescale 1ns/1ps
// Transaction sequencer: chip select, serial clock, phase counting and
// transmit lanes. Each serial beat is two system clocks (low, then high).
// Lanes change only when the serial clock falls. Settings are latched
// on start.
module qspi_phase_seq
    import qspi_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int NUM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        mode_byte,
    input  rd_cfg_t           cfg,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic              sample_en,
    output lw_t               data_w
);

    localparam int DATA_BITS = NUM_BYTES * 8;
    localparam int SR_W      = 8 + ADDR_W + 8;
    localparam int MAXB      = (DATA_BITS > ADDR_W) ? ((DATA_BITS > 32) ? DATA_BITS : 32)
                                                    : ((ADDR_W > 32) ? ADDR_W : 32);
    localparam int CNT_W     = $clog2(MAXB + 1);

    phase_e          st, nxt_st;
    logic            hi;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [SR_W-1:0] sr;
    lw_t             lw_inst, lw_addr, lw_data, w_cur;
    logic            l_mode_en;
    logic [4:0]      l_dummy;
    logic            last;

    // Width of the phase currently on the bus.
    always_comb begin
        case (st)
            PH_INST:          w_cur = lw_inst;
            PH_ADDR, PH_MODE: w_cur = lw_addr;
            default:          w_cur = lw_data;
        endcase
    end

    // Next phase and its beat count at the end of a beat.
    always_comb begin
        last    = (cnt == '0);
        nxt_st  = st;
        nxt_cnt = cnt - 1'b1;
        if (last) begin
            case (st)
                PH_INST: begin
                    nxt_st  = PH_ADDR;
                    nxt_cnt = CNT_W'((ADDR_W >> lw_addr) - 1);
                end
                PH_ADDR, PH_MODE: begin
                    if (st == PH_ADDR && l_mode_en) begin
                        nxt_st  = PH_MODE;
                        nxt_cnt = CNT_W'((8 >> lw_addr) - 1);
                    end else if (l_dummy != 5'd0) begin
                        nxt_st  = PH_DUMMY;
                        nxt_cnt = CNT_W'(l_dummy - 5'd1);
                    end else begin
                        nxt_st  = PH_DATA;
                        nxt_cnt = CNT_W'((DATA_BITS >> lw_data) - 1);
                    end
                end
                PH_DUMMY: begin
                    nxt_st  = PH_DATA;
                    nxt_cnt = CNT_W'((DATA_BITS >> lw_data) - 1);
                end
                default: begin
                    nxt_st  = PH_IDLE;
                    nxt_cnt = '0;
                end
            endcase
        end
    end

    // Main sequencer: accept start, toggle the clock, advance the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PH_IDLE; hi <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
            cnt <= '0; sr <= '0;
            lw_inst <= 2'd0; lw_addr <= 2'd0; lw_data <= 2'd0;
            l_mode_en <= 1'b0; l_dummy <= 5'd0;
        end else if (st == PH_IDLE) begin
            if (start) begin
                lw_inst   <= cfg.w_inst;
                lw_addr   <= cfg.w_addr;
                lw_data   <= cfg.w_data;
                l_mode_en <= cfg.mode_en;
                l_dummy   <= cfg.dummy;
                sr        <= {cfg.opcode, start_addr, mode_byte};
                cnt       <= CNT_W'((8 >> cfg.w_inst) - 1);
                st        <= PH_INST;
                cs_n      <= 1'b0;
                hi        <= 1'b0;
            end
        end else if (!hi) begin
            sclk <= 1'b1;
            hi   <= 1'b1;
        end else begin
            sclk <= 1'b0;
            hi   <= 1'b0;
            st   <= nxt_st;
            cnt  <= nxt_cnt;
            if (st == PH_INST || st == PH_ADDR || st == PH_MODE)
                sr <= sr << (1 << w_cur);
            if (st == PH_DATA && last)
                cs_n <= 1'b1;
        end
    end

    // Lane drive: command phases from the shift register, input phases idle.
    always_comb begin
        dq_out = 4'b0000;
        dq_oe  = 4'b0000;
        case (st)
            PH_INST, PH_ADDR, PH_MODE: begin
                dq_oe = lane_mask(w_cur);
                case (w_cur)
                    2'd0:    dq_out = {3'b000, sr[SR_W-1]};
                    2'd1:    dq_out = {2'b00, sr[SR_W-1 -: 2]};
                    default: dq_out = sr[SR_W-1 -: 4];
                endcase
            end
            PH_DUMMY, PH_DATA: dq_oe = (lw_data == 2'd0) ? 4'b0001 : 4'b0000;
            default: ;
        endcase
    end

    assign busy      = (st != PH_IDLE);
    assign sample_en = (st == PH_DATA) && !hi;
    assign data_w    = lw_data;

    AST_SCLK_LOW_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R3
    AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n); // R3
    AST_CS_FALL_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk); // R3
    AST_INPUT_LANES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_DATA || st == PH_DUMMY) |-> (dq_oe[3:1] == 3'b000 && dq_out == 4'b0000)); // R10

endmodule

// File: rtl/qspi_rx_pack.sv
`timescale 1ns/1ps
// Receive packer: collects 1, 2 or 4 bits per sample edge, MSB first,
// and emits each completed byte with a one-clock strobe. Assumes the byte
// count times eight is a multiple of the lane count.
module qspi_rx_pack
    import qspi_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  lw_t        w,
    input  logic [3:0] dq_in,
    output logic [7:0] rd_data,
    output logic       rd_valid
);

    logic [7:0] acc, nxt;
    logic [3:0] fill, fill_nxt;

    // Merge the incoming lanes below the bits already held.
    always_comb begin
        case (w)
            2'd0:    nxt = {acc[6:0], dq_in[1]};
            2'd1:    nxt = {acc[5:0], dq_in[1:0]};
            default: nxt = {acc[3:0], dq_in};
        endcase
        fill_nxt = fill + (4'd1 << w);
    end

    // Accumulate and present complete bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= 8'h00; fill <= 4'd0; rd_data <= 8'h00; rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (sample_en) begin
                acc <= nxt;
                if (fill_nxt == 4'd8) begin
                    rd_data  <= nxt;
                    rd_valid <= 1'b1;
                    fill     <= 4'd0;
                end else begin
                    fill <= fill_nxt;
                end
            end
        end
    end

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R9

endmodule

// File: rtl/qspi_read_seq.sv
`timescale 1ns/1ps
// Top of the quad-lane flash read sequencer: configuration word,
// transaction sequencer and receive packer. The serial clock is half
// the system clock, and a fixed NUM_BYTES bytes are read per start.
module qspi_read_seq
    import qspi_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int NUM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        mode_byte,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic [3:0]        dq_in,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);

    rd_cfg_t cfg;
    logic    sample_en;
    lw_t     data_w;

    qspi_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .cfg(cfg)
    );

    qspi_phase_seq #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mode_byte(mode_byte), .cfg(cfg), .cs_n(cs_n), .sclk(sclk),
        .busy(busy), .dq_out(dq_out), .dq_oe(dq_oe),
        .sample_en(sample_en), .data_w(data_w)
    );

    qspi_rx_pack u_rx (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .w(data_w),
        .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: tb/test_qspi_read_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts every serial beat and every
// received byte; the monitor compares them as the design produces them.
module test_qspi_read_seq;

    localparam int NB = 4;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    mode_byte = '0;
    logic          busy, cs_n, sclk, rd_valid;
    logic [3:0]    dq_out, dq_oe;
    logic [3:0]    dq_in = 4'b1010;
    logic [7:0]    rd_data;

    always #2.5 clk = ~clk;

    qspi_read_seq #(.ADDR_W(AW), .NUM_BYTES(NB)) i_qspi_read_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .start(start), .start_addr(start_addr),
        .mode_byte(mode_byte), .busy(busy), .cs_n(cs_n), .sclk(sclk),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_oe[$];
    logic [7:0] exp_val[$];
    string      exp_tag[$];
    logic [7:0] exp_bytes[$];
    logic [7:0] stream[NB];
    int         tx_total = 0;
    int         tx_data_start = 0;
    int         tx_wd = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] eff_code(input logic [1:0] c);
        return (c == 2'd3) ? 2'd0 : c;
    endfunction

    function automatic logic sbit(input int p);
        if (p < 0 || p >= NB * 8) return 1'b0;
        return stream[p / 8][7 - (p % 8)];
    endfunction

    // Flash model output for serial beat k of the current frame.
    function automatic logic [3:0] drive_for(input int k);
        int j, p;
        j = k - tx_data_start;
        if (j < 0) return 4'b1010;
        p = j * (1 << tx_wd);
        case (tx_wd)
            0:       return {2'b11, sbit(p), ~sbit(p)};
            1:       return {2'b11, sbit(p), sbit(p + 1)};
            default: return {sbit(p), sbit(p + 1), sbit(p + 2), sbit(p + 3)};
        endcase
    endfunction

    // Predict the beats of one field, MSB first, high lane most significant.
    task automatic push_field(input logic [31:0] v, input int nbits, input int w,
                              input string tag);
        int lanes;
        lanes = 1 << w;
        for (int i = 0; i < nbits / lanes; i++) begin
            logic [3:0] val;
            val = 4'b0000;
            for (int l = 0; l < lanes; l++)
                val[l] = v[nbits - 1 - i * lanes - (lanes - 1 - l)];
            exp_oe.push_back({4'b0000, 4'((1 << lanes) - 1)});
            exp_val.push_back({4'b0000, val});
            exp_tag.push_back(tag);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Driver: configure, predict, start, optionally poke start mid-frame.
    task automatic run_txn(input logic [31:0] cw, input logic [23:0] addr,
                           input logic [7:0] mb, input int seed, input bit poke,
                           input string itag);
        int wi, wa, wd, nd, ndata;
        bit me;
        write_cfg(cw);
        wi = eff_code(cw[9:8]);
        wa = (wi != 0) ? wi : eff_code(cw[13:12]);
        wd = (wi != 0) ? wi : eff_code(cw[17:16]);
        me = cw[20];
        nd = cw[28:24];
        ndata = (NB * 8) >> wd;
        push_field({24'h0, cw[7:0]}, 8, wi, itag);
        push_field({8'h0, addr}, 24, wa, "R5");
        if (me) push_field({24'h0, mb}, 8, wa, "R7");
        for (int i = 0; i < nd; i++) begin
            exp_oe.push_back((wd == 0) ? 8'h01 : 8'h00);
            exp_val.push_back(8'h00);
            exp_tag.push_back("R8/R10");
        end
        for (int i = 0; i < ndata; i++) begin
            exp_oe.push_back((wd == 0) ? 8'h01 : 8'h00);
            exp_val.push_back(8'h00);
            exp_tag.push_back("R10");
        end
        for (int b = 0; b < NB; b++) begin
            stream[b] = 8'((seed * 37 + b * 89) ^ 8'h5A);
            exp_bytes.push_back(stream[b]);
        end
        tx_total      = (8 >> wi) + (24 >> wa) + (me ? (8 >> wa) : 0) + nd + ndata;
        tx_data_start = tx_total - ndata;
        tx_wd         = wd;
        @(negedge clk); start = 1'b1; start_addr = addr; mode_byte = mb;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (7) @(negedge clk);
            start = 1'b1; start_addr = ~addr; mode_byte = ~mb;
            @(negedge clk); start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_oe.size() == 0, "R3", "beats not seen", exp_oe.size(), 0);
        check(exp_bytes.size() == 0, "R9", "bytes not received", exp_bytes.size(), 0);
        repeat (6) begin
            @(negedge clk);
            check(cs_n == 1'b1 && sclk == 1'b0, "R12", "bus stays idle after frame",
                  {cs_n, sclk}, 2'b10);
        end
    endtask

    // Monitor: compare beats on each serial rise, bytes on each strobe.
    logic prev_sclk = 1'b0;
    logic prev_cs = 1'b1;
    int   beat_idx = 0;
    int   cs_cnt = 0;
    bit   busy_bad = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                if (exp_oe.size() == 0) begin
                    check(1'b0, "R3", "unexpected serial edge", beat_idx, tx_total);
                end else begin
                    logic [7:0] eo, ev;
                    string tg;
                    eo = exp_oe.pop_front();
                    ev = exp_val.pop_front();
                    tg = exp_tag.pop_front();
                    check(dq_oe == eo[3:0] && (dq_out & eo[3:0]) == ev[3:0], tg,
                          "lane drive {oe,out}", {dq_oe, dq_out & eo[3:0]}, {eo[3:0], ev[3:0]});
                end
                beat_idx++;
            end
            if (busy != !cs_n) busy_bad = 1'b1;
            if (!cs_n) cs_cnt++;
            if (cs_n && !prev_cs) begin
                check(cs_cnt == 2 * tx_total, "R3", "chip select low clocks", cs_cnt, 2 * tx_total);
                check(!busy_bad, "R3", "busy tracks chip select", busy_bad, 0);
                cs_cnt = 0;
                busy_bad = 1'b0;
            end
            if (cs_n) beat_idx = 0;
            dq_in = drive_for(beat_idx);
            if (rd_valid) begin
                if (exp_bytes.size() == 0) begin
                    check(1'b0, "R9", "unexpected byte", rd_data, 0);
                end else begin
                    logic [7:0] eb;
                    eb = exp_bytes.pop_front();
                    check(rd_data == eb, "R9", "received byte", rd_data, eb);
                end
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 32'h0000_0003, "R1", "reset configuration", cfg_rdata, 32'h3);
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R3", "idle bus after reset",
              {cs_n, sclk, busy}, 3'b100);
        check(dq_oe == 4'b0000, "R10", "no lane driven when idle", dq_oe, 0);

        write_cfg(32'hFFFF_FFFF);
        @(negedge clk);
        check(cfg_rdata == 32'h1F13_33FF, "R2", "all-ones write", cfg_rdata, 32'h1F1333FF);
        write_cfg(32'hE0EC_CC00);
        @(negedge clk);
        check(cfg_rdata == 32'h0, "R2", "reserved-only write", cfg_rdata, 0);
        repeat (3) @(negedge clk);
        check(cfg_rdata == 32'h0, "R2", "value held without write", cfg_rdata, 0);

        // R4 R5 R9: all single lane, plain read, no dummy.
        run_txn(32'h0000_0003, 24'h5AC30F, 8'h00, 1, 1'b0, "R4");
        // R7 R8: quad address and data, mode byte, 8 dummy clocks.
        run_txn(32'h0812_200B, 24'h123456, 8'hA5, 2, 1'b0, "R4");
        // R6: dual instruction overrides quad address and single data.
        run_txn(32'h0100_213B, 24'hC0FFEE, 8'h00, 3, 1'b0, "R6");
        // R6 R8: quad instruction, mode byte, 31 dummy clocks.
        run_txn(32'h1F10_02EB, 24'h0F1E2D, 8'h3C, 4, 1'b0, "R6");
        // R11: code 3 in every width field means single lane.
        run_txn(32'h0003_336B, 24'h8001FE, 8'h00, 5, 1'b0, "R11");
        // R12: dual address and data with mode byte, start poked while busy.
        run_txn(32'h0011_10BB, 24'hA55A0F, 8'h96, 6, 1'b1, "R4");
        // R10: single data with one dummy clock keeps DQ0 driven low.
        run_txn(32'h0100_0003, 24'hFFFFFF, 8'h00, 7, 1'b0, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule